// File: doc/BRIEF.md
# Multi-Resolution Raster Scan and Pixel Fetch

This block drives a 640x480 display from a 25 MHz pixel clock. It keeps the horizontal and vertical scan position, makes the two sync pulses and the blanking signal, and opens an image window whose size depends on a view selection. While the window is open it walks a read address through a frame store in raster order. The 12-bit word that comes back one cycle later is widened to three 8-bit colour channels and also given out as 4-bit channels for a resistor DAC.

In the full view, the address is divided by four before it reaches the memory. A store one quarter the size of the screen can then feed the whole 640x480 raster, because four neighbouring pixels share one word. In the two reduced views the window covers the top-left half-size or quarter-size region, and the low address bits go to the store unchanged. Sync, blanking and window flags are registered once so that they line up with the memory's read latency.

Top module: `vga_scan_fetch`

## Requirements
- R1: `hsync_n` is low for exactly H_SYNC clocks of every H_TOTAL-clock line. The pulse begins H_ACTIVE+H_FP clocks after the line starts, where H_TOTAL = H_ACTIVE+H_FP+H_SYNC+H_BP.
- R2: `vsync_n` is low for exactly V_SYNC whole lines of every frame. The pulse begins at the start of line V_ACTIVE+V_FP, and a frame has V_ACTIVE+V_FP+V_SYNC+V_BP lines.
- R3: `blank_n` is high exactly at scan positions with column < H_ACTIVE and line < V_ACTIVE. `sync_n` is low whenever either sync is low.
- R4: `active_area` is high at column < W and line < H. When `sel_quarter` is high, W,H = H_ACTIVE/4, V_ACTIVE/4. When only `sel_half` is high, they are H_ACTIVE/2, V_ACTIVE/2. When neither is high, they are H_ACTIVE, V_ACTIVE. `sel_quarter` takes priority when both are high.
- R5: Sync, blank and window outputs are registered. After the k-th clock out of reset, they describe scan position k-1, and position 0 is column 0 of line 0.
- R6: The internal read index starts at 0 and goes up by one for each window position, in raster order. It holds at every other position.
- R7: The read index returns to 0 on the clock after any scan position inside the vertical sync lines.
- R8: In the full view, `mem_addr` is the read index shifted right by two. In the reduced views, it is the low MEM_AW bits of the index.
- R9: `rd_data` holds red in bits [11:8], green in [7:4] and blue in [3:0]. Each 8-bit output repeats its nibble twice, and each 4-bit output is the upper nibble of its 8-bit channel.
- R10: All colour outputs are zero in any cycle where `active_area` is low.
- R11: While `rst` is high, the outputs are as follows: `hsync_n`, `vsync_n` and `sync_n` are high, `blank_n` and `active_area` are low, `mem_addr` is 0, and every colour output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_quarter | input | 1 | Select the quarter-size window |
| sel_half | input | 1 | Select the half-size window |
| rd_data | input | 12 | Pixel word from the frame store, one cycle after `mem_addr` |
| mem_addr | output | MEM_AW | Frame store read address |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| blank_n | output | 1 | High during the visible raster |
| sync_n | output | 1 | Combined sync, active low |
| active_area | output | 1 | High inside the selected image window |
| red | output | 8 | Red channel |
| green | output | 8 | Green channel |
| blue | output | 8 | Blue channel |
| vga_r | output | 4 | Red for the 4-bit DAC |
| vga_g | output | 4 | Green for the 4-bit DAC |
| vga_b | output | 4 | Blue for the 4-bit DAC |

## Verification
The bench builds the block with a 16x12 visible raster, porches of 2/3/3 clocks and 1/2/2 lines, and a 10-bit read index. A frame then takes 408 clocks, and the quarter window is 4x3. This small setup lets every scan position of two whole frames be checked in each view, including the case with both selections high. It covers the wrap of the read index at vertical sync, the divide-by-four addressing, and the window edges. A bench memory returns a computed word one cycle late, so the colour expansion and the one-cycle alignment are checked against many different nibble patterns.

// File: rtl/vsf_pkg.sv
package vsf_pkg;

  typedef enum logic [1:0] {
    VIEW_FULL    = 2'd0,
    VIEW_HALF    = 2'd1,
    VIEW_QUARTER = 2'd2
  } view_t;

  // Scan-position flags for one pixel clock
  typedef struct packed {
    logic hs_n;
    logic vs_n;
    logic vis;
    logic win;
  } scan_t;

  function automatic view_t pick_view(input logic sel_q, input logic sel_h);
    if (sel_q)      return VIEW_QUARTER;
    else if (sel_h) return VIEW_HALF;
    else            return VIEW_FULL;
  endfunction

endpackage

// File: rtl/vsf_timing.sv
module vsf_timing
  import vsf_pkg::*;
#(
  parameter int H_ACTIVE = 640,
  parameter int H_FP     = 16,
  parameter int H_SYNC   = 96,
  parameter int H_BP     = 48,
  parameter int V_ACTIVE = 480,
  parameter int V_FP     = 10,
  parameter int V_SYNC   = 2,
  parameter int V_BP     = 33
) (
  input  logic  clk,
  input  logic  rst,
  input  view_t view,
  output scan_t scan
);

  localparam int H_TOTAL = H_ACTIVE + H_FP + H_SYNC + H_BP;
  localparam int V_TOTAL = V_ACTIVE + V_FP + V_SYNC + V_BP;
  localparam int HW      = $clog2(H_TOTAL);
  localparam int VW      = $clog2(V_TOTAL);

  localparam logic [HW-1:0] H_LAST  = HW'(H_TOTAL - 1);
  localparam logic [VW-1:0] V_LAST  = VW'(V_TOTAL - 1);
  localparam logic [HW-1:0] H_VIS   = HW'(H_ACTIVE);
  localparam logic [HW-1:0] H_SY_LO = HW'(H_ACTIVE + H_FP);
  localparam logic [HW-1:0] H_SY_HI = HW'(H_ACTIVE + H_FP + H_SYNC);
  localparam logic [VW-1:0] V_VIS   = VW'(V_ACTIVE);
  localparam logic [VW-1:0] V_SY_LO = VW'(V_ACTIVE + V_FP);
  localparam logic [VW-1:0] V_SY_HI = VW'(V_ACTIVE + V_FP + V_SYNC);
  localparam logic [HW-1:0] H_HALF  = HW'(H_ACTIVE / 2);
  localparam logic [HW-1:0] H_QUAR  = HW'(H_ACTIVE / 4);
  localparam logic [VW-1:0] V_HALF  = VW'(V_ACTIVE / 2);
  localparam logic [VW-1:0] V_QUAR  = VW'(V_ACTIVE / 4);

  logic [HW-1:0] col;
  logic [VW-1:0] row;
  logic [HW-1:0] win_w;
  logic [VW-1:0] win_h;

  always_ff @(posedge clk) begin
    if (rst) begin
      col <= '0;
      row <= '0;
    end else if (col == H_LAST) begin
      col <= '0;
      row <= (row == V_LAST) ? '0 : row + 1'b1;
    end else begin
      col <= col + 1'b1;
    end
  end

  always_comb begin
    case (view)
      VIEW_QUARTER: begin win_w = H_QUAR; win_h = V_QUAR; end
      VIEW_HALF:    begin win_w = H_HALF; win_h = V_HALF; end
      default:      begin win_w = H_VIS;  win_h = V_VIS;  end
    endcase
  end

  always_comb begin
    scan.hs_n = !((col >= H_SY_LO) && (col < H_SY_HI));
    scan.vs_n = !((row >= V_SY_LO) && (row < V_SY_HI));
    scan.vis  = (col < H_VIS) && (row < V_VIS);
    scan.win  = (col < win_w) && (row < win_h);
  end

endmodule

// File: rtl/vsf_addr.sv
module vsf_addr
  import vsf_pkg::*;
#(
  parameter int ADDR_W = 19,
  localparam int MEM_AW = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  view_t             view,
  input  logic              win,
  input  logic              vs_n,
  output logic [MEM_AW-1:0] mem_addr
);

  logic [ADDR_W-1:0] idx;

  always_ff @(posedge clk) begin
    if (rst || !vs_n) idx <= '0;
    else if (win)     idx <= idx + 1'b1;
  end

  // Full view: four raster pixels share one stored word
  always_comb begin
    if (view == VIEW_FULL) mem_addr = idx[ADDR_W-1:2];
    else                   mem_addr = idx[MEM_AW-1:0];
  end

endmodule

// File: rtl/vsf_color.sv
module vsf_color #(
  parameter int CH_W = 4,
  localparam int PIX_W = 3 * CH_W
) (
  input  logic [PIX_W-1:0]  pix,
  input  logic              show,
  output logic [2*CH_W-1:0] ch_wide [3],
  output logic [CH_W-1:0]   ch_dac  [3]
);

  // Channel 0 = red (top nibble), 1 = green, 2 = blue
  for (genvar i = 0; i < 3; i++) begin : g_ch
    logic [CH_W-1:0] nib;
    assign nib        = pix[(2-i)*CH_W +: CH_W];
    assign ch_wide[i] = show ? {nib, nib} : '0;
    assign ch_dac[i]  = ch_wide[i][2*CH_W-1 -: CH_W];
  end

endmodule

// File: rtl/vga_scan_fetch.sv
module vga_scan_fetch
  import vsf_pkg::*;
#(
  parameter int H_ACTIVE = 640,
  parameter int H_FP     = 16,
  parameter int H_SYNC   = 96,
  parameter int H_BP     = 48,
  parameter int V_ACTIVE = 480,
  parameter int V_FP     = 10,
  parameter int V_SYNC   = 2,
  parameter int V_BP     = 33,
  parameter int ADDR_W   = 19,
  parameter int CH_W     = 4,
  localparam int MEM_AW  = ADDR_W - 2,
  localparam int PIX_W   = 3 * CH_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_quarter,
  input  logic              sel_half,
  input  logic [PIX_W-1:0]  rd_data,
  output logic [MEM_AW-1:0] mem_addr,
  output logic              hsync_n,
  output logic              vsync_n,
  output logic              blank_n,
  output logic              sync_n,
  output logic              active_area,
  output logic [2*CH_W-1:0] red,
  output logic [2*CH_W-1:0] green,
  output logic [2*CH_W-1:0] blue,
  output logic [CH_W-1:0]   vga_r,
  output logic [CH_W-1:0]   vga_g,
  output logic [CH_W-1:0]   vga_b
);

  view_t view;
  scan_t scan_now;
  logic  win_now;
  logic  vs_now_n;
  logic [2*CH_W-1:0] wide [3];
  logic [CH_W-1:0]   dac  [3];

  assign view     = pick_view(sel_quarter, sel_half);
  assign win_now  = scan_now.win;
  assign vs_now_n = scan_now.vs_n;

  vsf_timing #(
    .H_ACTIVE(H_ACTIVE), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_ACTIVE(V_ACTIVE), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP)
  ) u_timing (
    .clk  (clk),
    .rst  (rst),
    .view (view),
    .scan (scan_now)
  );

  vsf_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk      (clk),
    .rst      (rst),
    .view     (view),
    .win      (win_now),
    .vs_n     (vs_now_n),
    .mem_addr (mem_addr)
  );

  // One register stage matching the store's read latency
  always_ff @(posedge clk) begin
    if (rst) begin
      hsync_n     <= 1'b1;
      vsync_n     <= 1'b1;
      sync_n      <= 1'b1;
      blank_n     <= 1'b0;
      active_area <= 1'b0;
    end else begin
      hsync_n     <= scan_now.hs_n;
      vsync_n     <= scan_now.vs_n;
      sync_n      <= scan_now.hs_n & scan_now.vs_n;
      blank_n     <= scan_now.vis;
      active_area <= scan_now.win;
    end
  end

  vsf_color #(.CH_W(CH_W)) u_color (
    .pix     (rd_data),
    .show    (active_area),
    .ch_wide (wide),
    .ch_dac  (dac)
  );

  assign red   = wide[0];
  assign green = wide[1];
  assign blue  = wide[2];
  assign vga_r = dac[0];
  assign vga_g = dac[1];
  assign vga_b = dac[2];

endmodule

// File: rtl/vsf_checker.sv
module vsf_checker #(
  parameter int MEM_AW = 17,
  parameter int CW     = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              win_now,
  input logic              vs_now_n,
  input logic [MEM_AW-1:0] mem_addr,
  input logic              hsync_n,
  input logic              vsync_n,
  input logic              blank_n,
  input logic              active_area,
  input logic [CW-1:0]     red,
  input logic [CW-1:0]     green,
  input logic [CW-1:0]     blue
);

  // R6
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!win_now && vs_now_n) |=> $stable(mem_addr));

  // R7
  addr_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !vs_now_n |=> (mem_addr == '0));

  // R4
  window_in_raster_chk: assert property (@(posedge clk) disable iff (rst)
    active_area |-> blank_n);

  // R3
  hsync_in_blank_chk: assert property (@(posedge clk) disable iff (rst)
    !hsync_n |-> !blank_n);

  // R2
  vsync_line_start_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(vsync_n) |-> hsync_n);

  // R10
  black_outside_chk: assert property (@(posedge clk) disable iff (rst)
    !blank_n |-> (red == '0 && green == '0 && blue == '0));

endmodule

bind vga_scan_fetch vsf_checker #(.MEM_AW(MEM_AW), .CW(2*CH_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .win_now     (win_now),
  .vs_now_n    (vs_now_n),
  .mem_addr    (mem_addr),
  .hsync_n     (hsync_n),
  .vsync_n     (vsync_n),
  .blank_n     (blank_n),
  .active_area (active_area),
  .red         (red),
  .green       (green),
  .blue        (blue)
);

// File: tb/sim_vga_scan_fetch.sv
module sim_vga_scan_fetch;

  localparam int HA = 16, HF = 2, HS = 3, HB = 3;
  localparam int VA = 12, VF = 1, VS = 2, VB = 2;
  localparam int AW = 10;
  localparam int MW = AW - 2;
  localparam int HT = HA + HF + HS + HB;
  localparam int VT = VA + VF + VS + VB;
  localparam int FR = HT * VT;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel_quarter = 1'b0;
  logic sel_half = 1'b0;
  logic [11:0] rd_data = '0;
  logic [MW-1:0] mem_addr;
  logic hsync_n, vsync_n, blank_n, sync_n, active_area;
  logic [7:0] red, green, blue;
  logic [3:0] vga_r, vga_g, vga_b;

  int errors = 0;
  int checks = 0;
  int n = 0;
  int vmode = 0;
  logic [MW-1:0] la = '0;

  always #2 clk = ~clk;

  vga_scan_fetch #(
    .H_ACTIVE(HA), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
    .V_ACTIVE(VA), .V_FP(VF), .V_SYNC(VS), .V_BP(VB),
    .ADDR_W(AW), .CH_W(4)
  ) u0 (
    .clk(clk), .rst(rst), .sel_quarter(sel_quarter), .sel_half(sel_half),
    .rd_data(rd_data), .mem_addr(mem_addr), .hsync_n(hsync_n),
    .vsync_n(vsync_n), .blank_n(blank_n), .sync_n(sync_n),
    .active_area(active_area), .red(red), .green(green), .blue(blue),
    .vga_r(vga_r), .vga_g(vga_g), .vga_b(vga_b)
  );

  function automatic logic [11:0] memval(input int a);
    return 12'((a * 173 + 'h5A3) & 'hFFF);
  endfunction

  // Bench memory: one cycle of read latency
  always @(negedge clk) la = mem_addr;
  always @(posedge clk) rd_data <= memval(int'(la));
  always @(posedge clk) n <= rst ? 0 : n + 1;

  function automatic int win_w(input int m);
    return (m == 2) ? HA / 4 : (m == 1) ? HA / 2 : HA;
  endfunction
  function automatic int win_h(input int m);
    return (m == 2) ? VA / 4 : (m == 1) ? VA / 2 : VA;
  endfunction

  function automatic int addr_model(input int p, input int m);
    int x, y, lin, cnt, w, h;
    x = p % HT; y = (p / HT) % VT; lin = y * HT + x;
    w = win_w(m); h = win_h(m);
    if (lin > (VA + VF) * HT) cnt = 0;
    else if (y < h) cnt = y * w + ((x < w) ? x : w);
    else cnt = w * h;
    if (m == 0) return cnt >> 2;
    return cnt & ((1 << MW) - 1);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s n=%0d actual=%0d expected=%0d", tag, n, act, exp);
    end
  endtask

  task automatic check_cycle();
    int q, x, y, w, h, hs, vs, win, ex;
    logic [11:0] pv;
    q = (n - 1) % FR; x = q % HT; y = q / HT;
    w = win_w(vmode); h = win_h(vmode);
    hs = (x >= HA + HF && x < HA + HF + HS) ? 0 : 1;
    vs = (y >= VA + VF && y < VA + VF + VS) ? 0 : 1;
    win = (x < w && y < h) ? 1 : 0;
    check("R1 hsync_n", int'(hsync_n), hs);
    check("R2 vsync_n", int'(vsync_n), vs);
    check("R3 blank_n", int'(blank_n), (x < HA && y < VA) ? 1 : 0);
    check("R3 sync_n", int'(sync_n), hs & vs);
    check("R4 R5 active_area", int'(active_area), win);
    check("R6 R7 R8 mem_addr", int'(mem_addr), addr_model(n % FR, vmode));
    pv = memval(addr_model(q, vmode));
    ex = win ? int'(pv[11:8]) * 17 : 0;
    check("R9 R10 red", int'(red), ex);
    check("R9 vga_r", int'(vga_r), ex >> 4);
    ex = win ? int'(pv[7:4]) * 17 : 0;
    check("R9 R10 green", int'(green), ex);
    check("R9 vga_g", int'(vga_g), ex >> 4);
    ex = win ? int'(pv[3:0]) * 17 : 0;
    check("R9 R10 blue", int'(blue), ex);
    check("R9 vga_b", int'(vga_b), ex >> 4);
  endtask

  task automatic run_view(input logic sq, input logic sh, input int m);
    @(negedge clk);
    rst = 1'b1; sel_quarter = sq; sel_half = sh; vmode = m;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 hsync_n", int'(hsync_n), 1);
    check("R11 vsync_n", int'(vsync_n), 1);
    check("R11 sync_n", int'(sync_n), 1);
    check("R11 blank_n", int'(blank_n), 0);
    check("R11 active_area", int'(active_area), 0);
    check("R11 mem_addr", int'(mem_addr), 0);
    check("R11 colour", int'({red, green, blue}), 0);
    rst = 1'b0;
    for (int k = 0; k < 2 * FR + 7; k++) begin
      @(negedge clk);
      check_cycle();
    end
  endtask

  initial begin
    fork
      begin
        run_view(1'b0, 1'b0, 0);
        run_view(1'b0, 1'b1, 1);
        run_view(1'b1, 1'b0, 2);
        run_view(1'b1, 1'b1, 2);  // R4 priority of quarter view
      end
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule